// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the write-only configuration port of an audio rate-converter datapath. A host drives three wires: a shift clock, a serial data line and a latch enable. On every rising edge of the shift clock one data bit enters a 12-bit serial-to-parallel register. When the latch enable rises, the 12 most recently shifted bits form a frame. The first bit of the frame picks the destination register, and the other 11 bits are written into it.

The three wires come from outside and are asynchronous. Each one passes through a two-stage synchronizer, and edges are detected in the faster system clock. A frame whose leading bit is low loads the 11-bit attenuation target. A frame whose leading bit is high loads the mode flags: deemphasis enable, a two-bit deemphasis rate code, a +12 dB gain shift, a ratio-measurement accuracy select and two test bits. When the rate code changes, a single-cycle pulse is raised so that the mute logic downstream can react.

Top module: `serctl_port`

## Requirements
- R1: While reset is low, and after it, the attenuation target is 0x400, every mode flag is low, the rate code is 00 and the change pulse is low.
- R2: A data bit is taken only at a rising edge of the shift clock. A change on the data line while the shift clock is high has no effect.
- R3: A frame whose leading bit (D1) is 0 loads D2..D12 into the attenuation target as an unsigned value. D2 is the most significant bit and D12 the least significant.
- R4: A frame whose leading bit is 1 loads the flags. In this mapping D12 is the lowest payload bit: D12 is deemphasis enable, D10:D11 is the rate code (D10 is the high bit), D9 is the +12 dB shift, D8 is the ratio-accuracy select, and D6:D7 are the test bits (D6 high). D2..D5 are ignored, and the attenuation target is left unchanged.
- R5: An attenuation frame leaves every mode flag unchanged.
- R6: If more than 12 bits are shifted before the latch edge, only the last 12 are used.
- R7: The outputs change exactly 3 system clock edges after the latch enable input rises, and at no other time.
- R8: The rate-change pulse is high for exactly one cycle, in the cycle in which a flag frame changes the rate code. A flag frame that keeps the same code does not raise it, and neither does an attenuation frame.
- R9: The one-hot rate select decodes rate codes 00 and 01 to bit 0 (44.1 kHz), code 10 to bit 1 (48.0 kHz) and code 11 to bit 2 (32.0 kHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_le_i | input | 1 | Latch enable (asynchronous) |
| ser_dat_i | input | 1 | Serial data |
| atten_o | output | 11 | Attenuation target |
| deemph_en_o | output | 1 | Deemphasis enable |
| deemph_rate_o | output | 2 | Deemphasis rate code |
| deemph_rate_oh_o | output | 3 | One-hot rate select {32.0, 48.0, 44.1} |
| gain_boost_o | output | 1 | +12 dB gain shift |
| ratio_fine_o | output | 1 | Ratio-accuracy select |
| test_mode_o | output | 2 | Test bits |
| rate_change_o | output | 1 | One-cycle rate-change pulse |

## Verification
Every register and the rate-change pulse settle on the third system clock edge after the latch enable input rises: two synchronizer stages, then the register load. The driver changes the latch enable one time unit after a rising edge and files the expected item due on the fourth falling edge after that point. The monitor compares the item on exactly that falling edge. On every other falling edge it requires the pulse to be low, so a pulse that comes early, comes late or lasts too long is caught. Shift clock phases last four system cycles, which gives the synchronized data line time to settle before it is sampled.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int FRAME_W    = 12;
  localparam int PAYLOAD_W  = FRAME_W - 1;
  localparam int ATT_W      = PAYLOAD_W;
  localparam int RATE_W     = 2;
  localparam int TEST_W     = 2;
  localparam int RATE_OH_W  = 3;
  localparam logic [ATT_W-1:0] ATT_RESET = 11'h400;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic              ratio_fine;
    logic              gain_boost;
    logic [RATE_W-1:0] rate;
    logic              deemph_en;
  } mode_flags_t;

  localparam int FLAG_W = $bits(mode_flags_t);

  // Payload bit 0 is the last bit shifted (D12).
  function automatic mode_flags_t payload_to_flags(input logic [PAYLOAD_W-1:0] p);
    mode_flags_t f;
    f.deemph_en  = p[0];
    f.rate       = p[2:1];
    f.gain_boost = p[3];
    f.ratio_fine = p[4];
    f.test       = p[6:5];
    return f;
  endfunction

  function automatic logic [RATE_OH_W-1:0] rate_onehot(input logic [RATE_W-1:0] code);
    logic [RATE_OH_W-1:0] oh;
    case (code)
      2'b10:   oh = 3'b010;
      2'b11:   oh = 3'b100;
      default: oh = 3'b001;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/serctl_sync_edge.sv
module serctl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/serctl_shifter.sv
module serctl_shifter
  import serctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign frame_o = sr_q;
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [ATT_W-1:0]   atten_o,
  output mode_flags_t        flags_o,
  output logic               rate_chg_o
);
  logic                 sel_flags;
  logic [PAYLOAD_W-1:0] payload;
  mode_flags_t          next_flags;
  logic [ATT_W-1:0]     atten_q;
  mode_flags_t          flags_q;
  logic                 chg_q;

  assign sel_flags  = frame_i[FRAME_W-1];
  assign payload    = frame_i[PAYLOAD_W-1:0];
  assign next_flags = payload_to_flags(payload);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atten_q <= ATT_RESET;
      flags_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (load_i) begin
        if (sel_flags) begin
          flags_q <= next_flags;
          chg_q   <= (next_flags.rate != flags_q.rate);
        end else begin
          atten_q <= payload;
        end
      end
    end
  end

  assign atten_o    = atten_q;
  assign flags_o    = flags_q;
  assign rate_chg_o = chg_q;
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_clk_i,
  input  logic                 ser_le_i,
  input  logic                 ser_dat_i,
  output logic [ATT_W-1:0]     atten_o,
  output logic                 deemph_en_o,
  output logic [RATE_W-1:0]    deemph_rate_o,
  output logic [RATE_OH_W-1:0] deemph_rate_oh_o,
  output logic                 gain_boost_o,
  output logic                 ratio_fine_o,
  output logic [TEST_W-1:0]    test_mode_o,
  output logic                 rate_change_o
);
  logic               sck_lvl, sck_rise;
  logic               le_lvl, le_rise;
  logic               dat_lvl, dat_rise;
  logic [FRAME_W-1:0] frame_q;
  mode_flags_t        flags_q;

  serctl_sync_edge #(.STAGES(SYNC_STAGES)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ser_clk_i),
    .level_o(sck_lvl), .rise_o(sck_rise));
  serctl_sync_edge #(.STAGES(SYNC_STAGES)) u_le (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ser_le_i),
    .level_o(le_lvl), .rise_o(le_rise));
  serctl_sync_edge #(.STAGES(SYNC_STAGES)) u_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ser_dat_i),
    .level_o(dat_lvl), .rise_o(dat_rise));

  serctl_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sck_rise),
    .bit_i(dat_lvl), .frame_o(frame_q));

  serctl_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(le_rise), .frame_i(frame_q),
    .atten_o(atten_o), .flags_o(flags_q), .rate_chg_o(rate_change_o));

  assign deemph_en_o      = flags_q.deemph_en;
  assign deemph_rate_o    = flags_q.rate;
  assign deemph_rate_oh_o = rate_onehot(flags_q.rate);
  assign gain_boost_o     = flags_q.gain_boost;
  assign ratio_fine_o     = flags_q.ratio_fine;
  assign test_mode_o      = flags_q.test;
endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk
  import serctl_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 le_rise,
  input logic [FRAME_W-1:0]   frame_q,
  input logic [ATT_W-1:0]     atten_o,
  input logic [RATE_W-1:0]    deemph_rate_o,
  input logic [RATE_OH_W-1:0] deemph_rate_oh_o,
  input logic                 deemph_en_o,
  input logic                 rate_change_o
);
  assert_atten_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && !frame_q[FRAME_W-1]) |=> (atten_o == $past(frame_q[PAYLOAD_W-1:0])));

  assert_atten_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && frame_q[FRAME_W-1]) |=> $stable(atten_o));

  assert_flags_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise && !frame_q[FRAME_W-1]) |=> ($stable(deemph_rate_o) && $stable(deemph_en_o)));

  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise |=> ($stable(atten_o) && $stable(deemph_rate_o) && $stable(deemph_en_o)));

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_change_o |=> !rate_change_o);

  assert_pulse_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_change_o |-> (deemph_rate_o != $past(deemph_rate_o)));

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(deemph_rate_oh_o) == 1);
endmodule

bind serctl_port serctl_port_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .le_rise(le_rise), .frame_q(frame_q),
  .atten_o(atten_o), .deemph_rate_o(deemph_rate_o),
  .deemph_rate_oh_o(deemph_rate_oh_o), .deemph_en_o(deemph_en_o),
  .rate_change_o(rate_change_o));

// File: tb/serctl_port_tb_top.sv
module serctl_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, sle = 1'b0, sdat = 1'b0;
  logic [10:0] atten;
  logic        dem_en, gboost, rfine, rchg;
  logic [1:0]  rate, tmode;
  logic [2:0]  rate_oh;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  logic done = 1'b0;

  typedef struct {
    int          due;
    logic [10:0] att;
    logic [6:0]  flg;   // {test[1:0], fine, boost, rate[1:0], en}
    logic        chg;
  } exp_t;
  exp_t sb[$];

  logic [31:0] hist = '0;
  logic [10:0] m_att = 11'h400;
  logic [6:0]  m_flg = '0;

  serctl_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sck), .ser_le_i(sle), .ser_dat_i(sdat),
    .atten_o(atten), .deemph_en_o(dem_en), .deemph_rate_o(rate),
    .deemph_rate_oh_o(rate_oh), .gain_boost_o(gboost), .ratio_fine_o(rfine),
    .test_mode_o(tmode), .rate_change_o(rchg));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] want_oh(input logic [1:0] c);
    if (c == 2'b11) return 3'b100;
    if (c == 2'b10) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // monitor: pops scoreboard items on their due falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check("R3 atten", {21'b0, atten}, {21'b0, e.att});
        check("R4 flags", {25'b0, tmode, rfine, gboost, rate, dem_en}, {25'b0, e.flg});
        check("R9 onehot", {29'b0, rate_oh}, {29'b0, want_oh(e.flg[2:1])});
        check("R8 pulse", {31'b0, rchg}, {31'b0, e.chg});
      end else if (rchg !== 1'b0) begin
        fails++;
        $display("FAIL R8 stray pulse: actual %b expected 0", rchg);
      end
    end
  end

  task automatic shift_bit(input logic b, input bit glitch);
    sdat = b;
    repeat (HALF_SCK) @(posedge clk);
    #1 sck = 1'b1;
    hist = {hist[30:0], b};
    repeat (HALF_SCK) @(posedge clk);
    if (glitch) begin
      #1 sdat = ~b;   // R2: changes while clock high must be ignored
      repeat (HALF_SCK) @(posedge clk);
    end
    #1 sck = 1'b0;
  endtask

  task automatic send(input int n, input logic [31:0] bits, input bit glitch);
    exp_t e;
    logic [11:0] fr;
    logic [6:0]  nf;
    logic        c;
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i], glitch);
    repeat (HALF_SCK) @(posedge clk);
    fr = hist[11:0];
    c  = 1'b0;
    if (fr[11]) begin
      nf = fr[6:0];
      c  = (nf[2:1] != m_flg[2:1]);
      m_flg = nf;
    end else begin
      m_att = fr[10:0];
    end
    #1 sle = 1'b1;
    e.due = cyc + 4; e.att = m_att; e.flg = m_flg; e.chg = c;
    sb.push_back(e);
    repeat (8) @(posedge clk);
    #1 sle = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 atten reset", {21'b0, atten}, 32'h400);
    check("R1 flags reset", {25'b0, tmode, rfine, gboost, rate, dem_en}, 32'h0);
    check("R9 reset onehot", {29'b0, rate_oh}, 32'h1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    send(12, 32'h123, 1'b0);       // R3 attenuation
    send(12, 32'h7FF, 1'b1);       // R3 max, R2 glitching data
    send(12, 32'h000, 1'b0);       // R3 zero
    send(12, 32'h805, 1'b0);       // R4 deemph on, rate 10 -> pulse R8
    send(12, 32'h807, 1'b1);       // R8 rate 11 -> pulse
    send(12, 32'hF8F, 1'b0);       // R4 D2..D5 ignored, same rate: no pulse
    send(12, 32'h2AA, 1'b0);       // R5 atten write keeps flags
    send(16, 32'hA803, 1'b0);      // R6 extra leading bits: last 12 flag frame
    send(15, 32'h7055, 1'b1);      // R6 atten from last 12
    send(12, 32'h808, 1'b0);       // R9 code 00, boost on

    // R7: no latch edge, shift clock only: outputs must hold
    for (int i = 0; i < 12; i++) shift_bit(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check("R7 held atten", {21'b0, atten}, {21'b0, m_att});
    check("R7 held flags", {25'b0, tmode, rfine, gboost, rate, dem_en}, {25'b0, m_flg});

    // R1: reset again restores defaults
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 atten re-reset", {21'b0, atten}, 32'h400);
    check("R1 flags re-reset", {25'b0, tmode, rfine, gboost, rate, dem_en}, 32'h0);
    check("R1 pulse re-reset", {31'b0, rchg}, 32'h0);
    check("R8 queue drained", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule